// File: doc/BRIEF.md
# Narrow-to-wide DMA bus bridge

This bridge lets a DMA engine with a 32-bit data path and a classic Wishbone handshake reach a 64-bit pipelined Wishbone interconnect. Each upstream cycle becomes exactly one pipelined request downstream. That request is held until the interconnect stops stalling it. The bridge then waits for the acknowledge and hands back a single acknowledge upstream.

Writes are widened. The 32-bit word goes onto both halves of the 64-bit data bus, and the four byte selects are placed on the half that address bit 2 picks. Reads are narrowed by returning the half picked by the same registered address bit. A register sits on the request path and another on the response path. This breaks long timing paths and costs two cycles of latency. Only one transaction is in flight at a time.

Top module: `dma_wide_bridge`

## Requirements
- R1: After reset, dn_cyc_o, dn_stb_o and up_ack_o are low, and dn_stb_o is never high without dn_cyc_o.
- R2: The downstream address is the upstream byte address shifted right by 3 (the doubleword address). dn_we_o follows up_we_i. Address and selects stay stable while a stalled strobe is held.
- R3: On a write with up_adr_i[2]=0, dn_sel_o[3:0] carries up_sel_i and dn_sel_o[7:4] is zero. With up_adr_i[2]=1, dn_sel_o[7:4] carries up_sel_i and dn_sel_o[3:0] is zero.
- R4: On a write, dn_dat_o[31:0] and dn_dat_o[63:32] both equal up_dat_i.
- R5: On a read, up_dat_o equals dn_dat_i[31:0] when the request had up_adr_i[2]=0, and dn_dat_i[63:32] when it had up_adr_i[2]=1. The value is taken in the cycle dn_ack_i is high.
- R6: dn_stb_o rises one cycle after a request is first presented. up_ack_o is high 2 + S + A cycles after the request is first presented, where S is the number of stalled strobe cycles and A is the number of cycles from the accepted strobe to dn_ack_i. With S = 0 and A = 1 this gives 3 cycles.
- R7: dn_stb_o stays high while dn_stall_i is high. It drops after the first unstalled cycle, while dn_cyc_o stays high until dn_ack_i.
- R8: At most one transaction is outstanding. up_ack_o is a one-cycle pulse, and no new downstream strobe is issued while a transaction waits.
- R9: dn_cyc_o falls and up_ack_o rises in the cycle after dn_ack_i is sampled high.
- R10: A strobe with up_cyc_i low starts no transaction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| up_cyc_i | input | 1 | Upstream cycle valid |
| up_stb_i | input | 1 | Upstream strobe |
| up_we_i | input | 1 | Upstream write enable |
| up_adr_i | input | 32 | Upstream byte address |
| up_sel_i | input | 4 | Upstream byte selects |
| up_dat_i | input | 32 | Upstream write data |
| up_dat_o | output | 32 | Upstream read data |
| up_ack_o | output | 1 | Upstream acknowledge |
| dn_cyc_o | output | 1 | Downstream cycle |
| dn_stb_o | output | 1 | Downstream strobe |
| dn_we_o | output | 1 | Downstream write enable |
| dn_adr_o | output | 29 | Downstream doubleword address |
| dn_sel_o | output | 8 | Downstream byte selects |
| dn_dat_o | output | 64 | Downstream write data |
| dn_dat_i | input | 64 | Downstream read data |
| dn_ack_i | input | 1 | Downstream acknowledge |
| dn_stall_i | input | 1 | Downstream stall |

## Verification
The bench exercises both address halves for reads and writes. This tells correct lane steering apart from a swapped or fixed lane. It also separates the copied write data from the selected read half.

Slave timing is varied: zero to several stall cycles, and an acknowledge in the same cycle as acceptance or up to two cycles later. These patterns distinguish a strobe that is held too long or dropped too early, and they check the exact latency. Directed cases add a strobe without cycle and back-to-back transactions, which expose spurious starts and double acknowledges.

// File: rtl/dwb_pkg.sv
package dwb_pkg;
  typedef enum logic [1:0] {
    ST_IDLE,
    ST_REQ,
    ST_WAIT,
    ST_RESP
  } bridge_state_e;
endpackage

// File: rtl/dwb_ctrl.sv
module dwb_ctrl
  import dwb_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic up_cyc_i,
  input  logic up_stb_i,
  input  logic dn_stall_i,
  input  logic dn_ack_i,
  output logic accept_o,
  output logic done_o,
  output logic dn_cyc_o,
  output logic dn_stb_o
);
  bridge_state_e state_q, state_d;

  assign accept_o = (state_q == ST_IDLE) && up_cyc_i && up_stb_i;
  assign done_o   = ((state_q == ST_REQ) || (state_q == ST_WAIT)) && dn_ack_i;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: if (accept_o) state_d = ST_REQ;
      ST_REQ: begin
        if (dn_ack_i)         state_d = ST_RESP;
        else if (!dn_stall_i) state_d = ST_WAIT;
      end
      ST_WAIT: if (dn_ack_i) state_d = ST_RESP;
      // upstream strobe still shows the old request here; skip it
      ST_RESP: state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_IDLE;
    else         state_q <= state_d;
  end

  assign dn_cyc_o = (state_q == ST_REQ) || (state_q == ST_WAIT);
  assign dn_stb_o = (state_q == ST_REQ);
endmodule

// File: rtl/dwb_req_stage.sv
module dwb_req_stage #(
  parameter int ADDR_W = 32,
  parameter int UP_DW  = 32,
  parameter int DN_DW  = 64
) (
  input  logic                              clk_i,
  input  logic                              rst_ni,
  input  logic                              accept_i,
  input  logic                              up_we_i,
  input  logic [ADDR_W-1:0]                 up_adr_i,
  input  logic [UP_DW/8-1:0]                up_sel_i,
  input  logic [UP_DW-1:0]                  up_dat_i,
  output logic                              dn_we_o,
  output logic [ADDR_W-$clog2(DN_DW/8)-1:0] dn_adr_o,
  output logic [DN_DW/8-1:0]                dn_sel_o,
  output logic [DN_DW-1:0]                  dn_dat_o,
  output logic [$clog2(DN_DW/UP_DW)-1:0]    lane_o
);
  localparam int UP_SW  = UP_DW / 8;
  localparam int DN_SW  = DN_DW / 8;
  localparam int RATIO  = DN_DW / UP_DW;
  localparam int LANE_W = $clog2(RATIO);
  localparam int UP_OFF = $clog2(UP_SW);
  localparam int DN_OFF = $clog2(DN_SW);
  localparam int DN_AW  = ADDR_W - DN_OFF;

  logic [LANE_W-1:0] lane_n;
  logic [DN_SW-1:0]  sel_n;
  logic [DN_DW-1:0]  dat_n;
  logic              adr_unused;

  assign lane_n     = up_adr_i[UP_OFF +: LANE_W];
  assign adr_unused = ^up_adr_i[UP_OFF-1:0];

  for (genvar l = 0; l < RATIO; l++) begin : g_lane
    assign sel_n[l*UP_SW +: UP_SW] = (lane_n == LANE_W'(l)) ? up_sel_i : '0;
    assign dat_n[l*UP_DW +: UP_DW] = up_dat_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dn_we_o  <= 1'b0;
      dn_adr_o <= '0;
      dn_sel_o <= '0;
      dn_dat_o <= '0;
      lane_o   <= '0;
    end else if (accept_i) begin
      dn_we_o  <= up_we_i;
      dn_adr_o <= up_adr_i[ADDR_W-1:DN_OFF];
      dn_sel_o <= sel_n;
      dn_dat_o <= dat_n;
      lane_o   <= lane_n;
    end
  end

  if (DN_AW < 1) begin : g_bad
    initial $error("address too narrow");
  end
endmodule

// File: rtl/dwb_resp_stage.sv
module dwb_resp_stage #(
  parameter int UP_DW = 32,
  parameter int DN_DW = 64
) (
  input  logic                           clk_i,
  input  logic                           rst_ni,
  input  logic                           done_i,
  input  logic [$clog2(DN_DW/UP_DW)-1:0] lane_i,
  input  logic [DN_DW-1:0]               dn_dat_i,
  output logic [UP_DW-1:0]               up_dat_o,
  output logic                           up_ack_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      up_dat_o <= '0;
      up_ack_o <= 1'b0;
    end else begin
      up_ack_o <= done_i;
      if (done_i) up_dat_o <= dn_dat_i[lane_i*UP_DW +: UP_DW];
    end
  end
endmodule

// File: rtl/dma_wide_bridge.sv
module dma_wide_bridge #(
  parameter int ADDR_W = 32,
  parameter int UP_DW  = 32,
  parameter int DN_DW  = 64,
  localparam int DN_AW = ADDR_W - $clog2(DN_DW/8)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               up_cyc_i,
  input  logic               up_stb_i,
  input  logic               up_we_i,
  input  logic [ADDR_W-1:0]  up_adr_i,
  input  logic [UP_DW/8-1:0] up_sel_i,
  input  logic [UP_DW-1:0]   up_dat_i,
  output logic [UP_DW-1:0]   up_dat_o,
  output logic               up_ack_o,
  output logic               dn_cyc_o,
  output logic               dn_stb_o,
  output logic               dn_we_o,
  output logic [DN_AW-1:0]   dn_adr_o,
  output logic [DN_DW/8-1:0] dn_sel_o,
  output logic [DN_DW-1:0]   dn_dat_o,
  input  logic [DN_DW-1:0]   dn_dat_i,
  input  logic               dn_ack_i,
  input  logic               dn_stall_i
);
  localparam int LANE_W = $clog2(DN_DW / UP_DW);

  logic              accept, done;
  logic [LANE_W-1:0] lane;

  dwb_ctrl u_ctrl (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .up_cyc_i  (up_cyc_i),
    .up_stb_i  (up_stb_i),
    .dn_stall_i(dn_stall_i),
    .dn_ack_i  (dn_ack_i),
    .accept_o  (accept),
    .done_o    (done),
    .dn_cyc_o  (dn_cyc_o),
    .dn_stb_o  (dn_stb_o)
  );

  dwb_req_stage #(.ADDR_W(ADDR_W), .UP_DW(UP_DW), .DN_DW(DN_DW)) u_req (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .accept_i(accept),
    .up_we_i (up_we_i),
    .up_adr_i(up_adr_i),
    .up_sel_i(up_sel_i),
    .up_dat_i(up_dat_i),
    .dn_we_o (dn_we_o),
    .dn_adr_o(dn_adr_o),
    .dn_sel_o(dn_sel_o),
    .dn_dat_o(dn_dat_o),
    .lane_o  (lane)
  );

  dwb_resp_stage #(.UP_DW(UP_DW), .DN_DW(DN_DW)) u_resp (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .done_i  (done),
    .lane_i  (lane),
    .dn_dat_i(dn_dat_i),
    .up_dat_o(up_dat_o),
    .up_ack_o(up_ack_o)
  );
endmodule

// File: rtl/dma_wide_bridge_chk.sv
module dma_wide_bridge_chk #(
  parameter int DN_AW = 29,
  parameter int DN_DW = 64
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               up_ack_o,
  input logic               dn_cyc_o,
  input logic               dn_stb_o,
  input logic               dn_we_o,
  input logic [DN_AW-1:0]   dn_adr_o,
  input logic [DN_DW/8-1:0] dn_sel_o,
  input logic [DN_DW-1:0]   dn_dat_o,
  input logic               dn_ack_i,
  input logic               dn_stall_i
);
  localparam int HS = DN_DW / 16;
  localparam int HD = DN_DW / 2;

  // R1
  stb_in_cyc_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dn_stb_o |-> dn_cyc_o);
  // R2
  stall_stable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dn_stb_o && dn_stall_i |=> $stable(dn_adr_o) && $stable(dn_sel_o) && $stable(dn_we_o));
  // R3
  sel_one_half_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dn_stb_o && dn_we_o |-> (dn_sel_o[HS*2-1:HS] == '0) || (dn_sel_o[HS-1:0] == '0));
  // R4
  wdat_copy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dn_stb_o && dn_we_o |-> dn_dat_o[DN_DW-1:HD] == dn_dat_o[HD-1:0]);
  // R7
  stall_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dn_stb_o && dn_stall_i |=> dn_stb_o);
  // R7
  stb_drop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dn_stb_o && !dn_stall_i && !dn_ack_i |=> !dn_stb_o && dn_cyc_o);
  // R9
  ack_close_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dn_cyc_o && dn_ack_i |=> !dn_cyc_o && up_ack_o);
  // R8
  ack_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    up_ack_o |=> !up_ack_o && !dn_cyc_o);
endmodule

bind dma_wide_bridge dma_wide_bridge_chk #(.DN_AW(DN_AW), .DN_DW(DN_DW)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .up_ack_o  (up_ack_o),
  .dn_cyc_o  (dn_cyc_o),
  .dn_stb_o  (dn_stb_o),
  .dn_we_o   (dn_we_o),
  .dn_adr_o  (dn_adr_o),
  .dn_sel_o  (dn_sel_o),
  .dn_dat_o  (dn_dat_o),
  .dn_ack_i  (dn_ack_i),
  .dn_stall_i(dn_stall_i)
);

// File: tb/sim_dma_wide_bridge.sv
module sim_dma_wide_bridge;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        up_cyc_i = 0, up_stb_i = 0, up_we_i = 0;
  logic [31:0] up_adr_i = '0, up_dat_i = '0;
  logic [3:0]  up_sel_i = '0;
  logic [31:0] up_dat_o;
  logic        up_ack_o, dn_cyc_o, dn_stb_o, dn_we_o;
  logic [28:0] dn_adr_o;
  logic [7:0]  dn_sel_o;
  logic [63:0] dn_dat_o;
  logic [63:0] dn_dat_i = '0;
  logic        dn_ack_i = 0, dn_stall_i = 0;

  int checks = 0, errors = 0;
  bit done = 0;

  always #2 clk_i = ~clk_i;

  dma_wide_bridge u0 (.*);

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_sel(logic [31:0] adr, logic [3:0] sel);
    return adr[2] ? {sel, 4'b0} : {4'b0, sel};
  endfunction

  function automatic logic [31:0] exp_rd(logic [31:0] adr, logic [63:0] rd);
    return adr[2] ? rd[63:32] : rd[31:0];
  endfunction

  task automatic xfer(bit we, logic [31:0] adr, logic [3:0] sel, logic [31:0] wd,
                      logic [63:0] rd, int stall_n, int ack_dly);
    int cyc = 0;
    up_cyc_i = 1; up_stb_i = 1; up_we_i = we; up_adr_i = adr; up_sel_i = sel; up_dat_i = wd;
    @(negedge clk_i); cyc++;
    chk("R6 dn_stb rise", dn_stb_o, 1);
    chk("R2 dn_adr", dn_adr_o, adr[31:3]);
    chk("R2 dn_we", dn_we_o, we);
    if (we) begin
      chk("R3 dn_sel", dn_sel_o, exp_sel(adr, sel));
      chk("R4 dn_dat", dn_dat_o, {wd, wd});
    end
    dn_stall_i = (stall_n > 0);
    for (int k = 0; k < stall_n; k++) begin
      @(negedge clk_i); cyc++;
      chk("R7 stb held in stall", dn_stb_o, 1);
      if (k == stall_n - 1) dn_stall_i = 0;
    end
    if (ack_dly == 0) begin
      dn_ack_i = 1; dn_dat_i = rd;
    end else begin
      @(negedge clk_i); cyc++;
      chk("R7 stb dropped", dn_stb_o, 0);
      chk("R7 cyc kept", dn_cyc_o, 1);
      for (int k = 1; k < ack_dly; k++) begin
        @(negedge clk_i); cyc++;
        chk("R8 no early ack", up_ack_o, 0);
        chk("R8 no new stb", dn_stb_o, 0);
      end
      dn_ack_i = 1; dn_dat_i = rd;
    end
    @(negedge clk_i); cyc++;
    dn_ack_i = 0; dn_dat_i = ~rd;
    chk("R6 up_ack", up_ack_o, 1);
    chk("R6 latency", 64'(cyc), 64'(2 + stall_n + ack_dly));
    chk("R9 dn_cyc closed", dn_cyc_o, 0);
    if (!we) chk("R5 rdata", up_dat_o, exp_rd(adr, rd));
    up_cyc_i = 0; up_stb_i = 0;
    @(negedge clk_i);
    chk("R8 ack pulse", up_ack_o, 0);
    chk("R8 idle", dn_cyc_o, 0);
  endtask

  initial begin
    void'($urandom(32'h5eed_1234));
    repeat (3) @(negedge clk_i);
    chk("R1 cyc reset", dn_cyc_o, 0);
    chk("R1 stb reset", dn_stb_o, 0);
    chk("R1 ack reset", up_ack_o, 0);
    rst_ni = 1;
    @(negedge clk_i);
    // R10: strobe without cycle
    up_stb_i = 1; up_cyc_i = 0;
    repeat (4) begin
      @(negedge clk_i);
      chk("R10 no start", dn_cyc_o, 0);
    end
    up_stb_i = 0;
    // directed corners
    xfer(1, 32'h0000_1000, 4'hf, 32'hdead_beef, '0, 0, 1);
    xfer(1, 32'h0000_1004, 4'h5, 32'hcafe_f00d, '0, 0, 0);
    xfer(0, 32'h0000_2000, 4'hf, '0, 64'h1111_2222_3333_4444, 5, 2);
    xfer(0, 32'hffff_fffc, 4'hf, '0, 64'haaaa_bbbb_cccc_dddd, 0, 0);
    xfer(1, 32'h8000_0004, 4'h8, 32'h0123_4567, '0, 3, 0);
    for (int i = 0; i < 80; i++) begin
      xfer($urandom % 2, $urandom, $urandom, $urandom, {$urandom, $urandom},
           $urandom % 4, $urandom % 3);
    end
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!done) begin
      checks++; errors++;
      $display("FAIL R6 watchdog actual=hung expected=complete");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule